// File: doc/BRIEF.md
# Comma Word Aligner

This block turns a serial bit stream into 10-bit parallel words. It receives one bit per cycle of a bit-rate clock and raises a strobe once per word. It scans the incoming bits for either polarity of the 7-bit comma prefix. When a comma turns up off the current word boundary, the block moves the boundary so that the next comma in that alignment starts in bit 9 of the output word. The boundary is only ever moved by lengthening the byte period in progress. A period is never cut short, so a downstream byte-rate consumer never sees two strobes closer together than ten bit times.

The first bit received is placed in bit 9 of a word, and later bits fill the lower positions. Two control inputs set how the block reacts to commas. One turns alignment off completely, which is the setting to use while pseudo-random test traffic is received. The other keeps the byte phase fixed: commas are still seen, but they stay at whatever offset they arrive. Three status outputs report what happened: a per-word comma flag, a one-cycle realignment pulse, and an aligned level.

Top module: `comma_word_aligner`

## Requirements
- R1: A word whose bits 9..3 equal 7'b0011111 (positive-disparity comma prefix; bits 2..0 are don't-care) is emitted with `word_comma` high. This holds when the comma lies on the current boundary.
- R2: A word whose bits 9..3 equal 7'b1100000 (negative-disparity comma prefix) is emitted with `word_comma` high. A word carrying neither prefix in bits 9..3 has `word_comma` low.
- R3: After a realignment, every later comma lying on the new boundary appears with its first bit in `word_out[9]`. The words that follow the comma continue in that alignment.
- R4: Two consecutive `word_valid` pulses are never less than 10 cycles apart. When a comma arrives d bit positions past the current boundary (1 <= d <= 9), the gap that spans the move is exactly 10 + d cycles.
- R5: A comma at a new offset, with alignment enabled and the phase not held, causes a one-cycle `realign` pulse. The pulse never coincides with `word_valid`. The comma's own word is not emitted, and the next word begins 10 bits after the comma's first bit.
- R6: While `hold_phase` is 1, commas at other offsets cause neither a realignment nor any change of period. The words keep their old boundaries.
- R7: While `align_en` is 0, commas cause no realignment and no `realign` pulse. The word boundaries stay unchanged.
- R8: After reset, all outputs are 0. The first word is made of the first 10 bits received after reset (the first of them in bit 9) and appears 10 cycles later.
- R9: `aligned` is 0 after reset and after every realignment. It becomes 1 when a word carrying a comma in bits 9..3 is emitted.
- R10: A comma that arrives on the boundary already in use causes no `realign` pulse and no change of period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data, one bit per cycle |
| align_en | input | 1 | 1 allows comma alignment; 0 turns it off |
| hold_phase | input | 1 | 1 keeps the byte phase fixed while still reporting commas |
| word_out | output | 10 | Parallel word; bit 9 holds the earliest bit |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| word_comma | output | 1 | High with `word_valid` when bits 9..3 hold a comma prefix |
| realign | output | 1 | One-cycle pulse when the word boundary is moved |
| aligned | output | 1 | Level: a comma has been emitted at bit 9 since the last move |

## Verification
Several properties are checked on every cycle. The strobe spacing never drops below ten bit times. Each comma flag comes with a valid word whose top seven bits really hold a prefix. A realignment pulse lasts exactly one cycle, never lands on a strobe, and only occurs when alignment is enabled and not held. Other behaviour can only be shown by the bench's scenarios: the exact 10 + d stretch, the loss of the comma's own word, which bits make up each word before and after the move, and the fact that hold mode and disabled mode leave the boundaries alone. The bench shows these by comparing the full word sequence and its timing against streams with known comma offsets.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  localparam int PFX_W = 7;
  localparam logic [PFX_W-1:0] PFX_POS = 7'b0011111;
  localparam logic [PFX_W-1:0] PFX_NEG = 7'b1100000;

  // True when the slice holds either polarity of the comma prefix
  function automatic logic is_comma(input logic [PFX_W-1:0] s);
    return (s == PFX_POS) || (s == PFX_NEG);
  endfunction
endpackage

// File: rtl/cwa_shifter.sv
module cwa_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  output logic [W-1:0] window
);
  logic [W-1:0] stage_q;

  // Bit 0 holds the newest bit; the oldest bit sits at W-1
  for (genvar i = 0; i < W; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else if (i == 0) stage_q[i] <= bit_in;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign window = stage_q;
endmodule

// File: rtl/cwa_detect.sv
module cwa_detect #(
  parameter int W = 10
) (
  input  logic [W-1:0] window,
  output logic         hit
);
  import cwa_pkg::*;
  // Look for a prefix that would sit in bits W-1 .. W-PFX_W if a word closed now
  assign hit = is_comma(window[W-1 -: PFX_W]);
endmodule

// File: rtl/cwa_phase.sv
module cwa_phase #(
  parameter int W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic move_ok,
  output logic boundary,
  output logic restart
);
  localparam int PH_W = $clog2(W + 1);
  logic [PH_W-1:0] ph_q;

  // ph_q counts the bits gathered since the last (real or virtual) boundary
  assign boundary = (ph_q == PH_W'(W));
  assign restart  = hit && !boundary && move_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else if (boundary || restart) ph_q <= PH_W'(1);
    else ph_q <= ph_q + PH_W'(1);
  end

  // A restart can only push the boundary later: the counter never passes W
  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= PH_W'(W));
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         align_en,
  input  logic         hold_phase,
  output logic [W-1:0] word_out,
  output logic         word_valid,
  output logic         word_comma,
  output logic         realign,
  output logic         aligned
);
  localparam int GAP_W = $clog2(2 * W + 2) + 1;

  logic [W-1:0] window;
  logic         hit;
  logic         boundary;
  logic         restart;
  logic         move_ok;

  assign move_ok = align_en && !hold_phase;

  cwa_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .window(window)
  );

  cwa_detect #(.W(W)) u_det (
    .window(window), .hit(hit)
  );

  cwa_phase #(.W(W)) u_phase (
    .clk(clk), .rst_n(rst_n), .hit(hit), .move_ok(move_ok),
    .boundary(boundary), .restart(restart)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out   <= '0;
      word_valid <= 1'b0;
      word_comma <= 1'b0;
      realign    <= 1'b0;
      aligned    <= 1'b0;
    end else begin
      word_valid <= boundary;
      word_comma <= boundary && hit;
      realign    <= restart;
      if (boundary) word_out <= window;
      if (restart) aligned <= 1'b0;
      else if (boundary && hit) aligned <= 1'b1;
    end
  end

  // Independent strobe-gap counter for the period checks
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (word_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GAP_W{1'b1}}) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  assert_min_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && seen_q) |-> (gap_q >= GAP_W'(W - 1)));

  assert_flag_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_comma |-> (word_valid &&
      (word_out[W-1 -: 7] == 7'b0011111 || word_out[W-1 -: 7] == 7'b1100000)));

  assert_flag_missing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && (word_out[W-1 -: 7] == 7'b1100000)) |-> word_comma);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> !realign);

  assert_pulse_not_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> !word_valid);

  assert_pulse_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(realign) |-> ($past(align_en) && !$past(hold_phase)));

  assert_aligned_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    realign |-> !aligned);
endmodule

// File: tb/tb_comma_word_aligner.sv
module tb_comma_word_aligner;
  localparam int W = 10;
  localparam logic [9:0] FILL = 10'b1010101010;
  localparam logic [9:0] KPOS = 10'b0011111010;
  localparam logic [9:0] KNEG = 10'b1100000101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic align_en = 1'b1;
  logic hold_phase = 1'b0;
  logic [W-1:0] word_out;
  logic word_valid, word_comma, realign, aligned;

  always #4 clk = ~clk;

  comma_word_aligner #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .align_en(align_en),
    .hold_phase(hold_phase), .word_out(word_out), .word_valid(word_valid),
    .word_comma(word_comma), .realign(realign), .aligned(aligned)
  );

  int checks = 0;
  int errors = 0;
  logic stream[$];
  int   exp_start[$];
  logic [W-1:0] exp_word[$];
  logic mon_on = 1'b0;
  int   cyc = 0;
  int   pulses = 0;
  int   prev_cyc = -1;
  int   prev_start = -1;
  string tag = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic has_prefix(input logic [W-1:0] w);
    return (w[9:3] == 7'b0011111) || (w[9:3] == 7'b1100000);
  endfunction

  function automatic logic [W-1:0] slice(input int s);
    logic [W-1:0] r;
    for (int j = 0; j < W; j++) r[W-1-j] = stream[s+j];
    return r;
  endfunction

  task automatic add_word(input logic [9:0] w);
    for (int j = 9; j >= 0; j--) stream.push_back(w[j]);
  endtask

  // Driver side of the scoreboard: expected words from the requirement rules
  task automatic plan_words(input int move_at);
    int s = 0;
    while (s + W <= stream.size() && (move_at < 0 || s < move_at)) begin
      exp_start.push_back(s); exp_word.push_back(slice(s)); s += W;
    end
    if (move_at >= 0) begin
      s = move_at + W;
      while (s + W <= stream.size()) begin
        exp_start.push_back(s); exp_word.push_back(slice(s)); s += W;
      end
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      if (realign) pulses++;
      if (word_valid) begin
        if (exp_word.size() == 0) begin
          check(1'b0, {tag, " extra word"}, int'(word_out), -1);
        end else begin
          logic [W-1:0] ew;
          int es;
          ew = exp_word.pop_front();
          es = exp_start.pop_front();
          check(word_out == ew, {tag, " word R3 R8"}, int'(word_out), int'(ew));
          check(word_comma == has_prefix(ew), {tag, " flag R1 R2"}, int'(word_comma), int'(has_prefix(ew)));
          if (prev_cyc >= 0)
            check((cyc - prev_cyc) == (es - prev_start), {tag, " gap R4"}, cyc - prev_cyc, es - prev_start);
          prev_cyc = cyc;
          prev_start = es;
        end
      end
    end
  end

  task automatic do_reset();
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    bit_in = 1'b0;
    @(negedge clk);
    check(word_valid == 0 && word_comma == 0 && realign == 0, "R8 reset strobes", int'(word_valid), 0);
    check(word_out == '0, "R8 reset word", int'(word_out), 0);
    check(aligned == 0, "R9 reset aligned", int'(aligned), 0);
  endtask

  task automatic run(input string name, input int move_at, input int exp_pulses, input logic exp_al);
    tag = name;
    plan_words(move_at);
    pulses = 0; prev_cyc = -1; prev_start = -1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int i = 0; i < stream.size(); i++) begin
      bit_in = stream[i];
      @(negedge clk);
    end
    bit_in = 1'b0; @(negedge clk);
    @(negedge clk);
    mon_on = 1'b0;
    check(exp_word.size() == 0, {name, " missing words R3"}, exp_word.size(), 0);
    check(pulses == exp_pulses, {name, " realign count R5 R6 R7 R10"}, pulses, exp_pulses);
    check(aligned == exp_al, {name, " aligned R9"}, int'(aligned), int'(exp_al));
    stream.delete(); exp_word.delete(); exp_start.delete();
  endtask

  task automatic build_offset_stream();
    stream.push_back(1'b1); stream.push_back(1'b0); stream.push_back(1'b1);
    add_word(FILL); add_word(FILL); add_word(KPOS); add_word(FILL);
    add_word(FILL); add_word(KNEG); add_word(FILL); add_word(FILL);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 R2 R8 R10: commas already on the boundary from reset
    do_reset();
    align_en = 1'b1; hold_phase = 1'b0;
    add_word(FILL); add_word(KPOS); add_word(FILL); add_word(FILL);
    add_word(KNEG); add_word(FILL); add_word(KPOS); add_word(FILL);
    run("on_boundary", -1, 0, 1'b1);

    // R3 R4 R5 R9: comma 3 bits off the boundary forces a 13-cycle period
    do_reset();
    build_offset_stream();
    run("shifted", 23, 1, 1'b1);

    // R6: phase held, commas stay at their offset
    do_reset();
    hold_phase = 1'b1;
    build_offset_stream();
    run("held", -1, 0, 1'b0);

    // R7: alignment disabled
    do_reset();
    hold_phase = 1'b0; align_en = 1'b0;
    build_offset_stream();
    run("disabled", -1, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule